// File: doc/BRIEF.md
# DAC Store Write Guard and Output Latch Policy

This block sits behind a serial instruction decoder in an adjustment-trim device. That device keeps a general word memory and a small bank of stored DAC codes in non-volatile cells. For every accepted instruction, the block decides two things: whether the addressed non-volatile word may be written, and whether a DAC channel's output latch is loaded. It keeps the programming-enable state, which the enable and disable instructions set and clear. It also takes in an active-high hardware unlock pin through a synchronizer. That pin gates the DAC code region only.

The address space is split by its most significant bit. When that bit is 0, the address is in general memory. When it is 1, the address is in the DAC code region, and the low bits select a channel. A DAC code write can move the analog output even while the store itself is write-disabled, so a trim can be tried out before it is committed. A read of a DAC code reloads that channel's latch from the stored value. The block's outputs are a memory write strobe, a one-hot latch load vector and the code to load. All outputs are registered.

Top module: `wr_guard_policy`

## Requirements
- R1: After reset, programming is disabled and `mem_we`, `latch_ld` and `latch_val` are all zero.
- R2: An accepted enable instruction (`op_code` 3) turns programming on. It stays on through any number of other operations and idle cycles until an accepted disable instruction (`op_code` 4) turns it off.
- R3: An accepted write (`op_code` 2) to a general address (`op_addr` MSB 0) pulses `mem_we` one cycle later only if programming is enabled. The unlock pin has no effect on this, and `latch_ld` stays zero.
- R4: An accepted write to a mapped DAC address, with the unlock pin high and programming enabled, pulses both `mem_we` and `latch_ld[ch]` one cycle later, with `latch_val` equal to `wr_data`.
- R5: An accepted write to a mapped DAC address, with the unlock pin high and programming disabled, pulses `latch_ld[ch]` with `latch_val` equal to `wr_data`, and leaves `mem_we` low.
- R6: An accepted write to a DAC address with the unlock pin low pulses neither `mem_we` nor any `latch_ld` bit.
- R7: An accepted read (`op_code` 1) never pulses `mem_we`. A read of a mapped DAC address pulses `latch_ld[ch]` with `latch_val` equal to `rd_data`, whatever the enable state and the unlock pin. A read of a general address loads no latch.
- R8: A DAC-region address whose low bits are NUM_CH or above (for example 0x104 to 0x107 with four channels) is unmapped, and accesses to it pulse no strobe.
- R9: Each strobe is high for only the cycle after an accepted read or write. Cycles with `op_valid` low, enable and disable instructions, and unused op codes 0 and 5 to 7 produce no strobe. Unused op codes also leave the enable state unchanged.
- R10: The unlock pin goes through PROT_SYNC flops. After the pin changes, operations accepted on the PROT_SYNC clock edges that follow the change still see the old level, and the next edge sees the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | A complete instruction is accepted this cycle |
| op_code | input | 3 | 1 read, 2 write, 3 enable programming, 4 disable programming |
| op_addr | input | ADDR_W | Target address; MSB selects the DAC region |
| wr_data | input | DAC_W | Write data (DAC code field) |
| rd_data | input | DAC_W | Stored code read back for the addressed word |
| dac_unlock | input | 1 | Hardware pin; low blocks the DAC region |
| mem_we | output | 1 | One-cycle non-volatile write strobe |
| latch_ld | output | NUM_CH | One-hot, one-cycle latch load per channel |
| latch_val | output | DAC_W | Code to load into the strobed latch |

## Verification
The bench uses the default build: ADDR_W=9, NUM_CH=4, DAC_W=8 and PROT_SYNC=2. This keeps the DAC region small, so a single sweep visits every mapped channel, four unmapped indices and several general addresses. The sweep runs with both reads and writes under all four combinations of unlock pin and enable state. A two-stage synchronizer also makes the edge-exact latency of a pin change directly testable with three back-to-back writes.

// File: rtl/wgp_pkg.sv
package wgp_pkg;
   typedef enum logic [2:0] {
      OPK_IDLE  = 3'd0,
      OPK_READ  = 3'd1,
      OPK_WRITE = 3'd2,
      OPK_PEN   = 3'd3,
      OPK_PDIS  = 3'd4
   } opk_e;
endpackage

// File: rtl/wgp_decode.sv
module wgp_decode
   import wgp_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int NUM_CH = 4
) (
   input  logic              valid,
   input  logic [2:0]        code,
   input  logic [ADDR_W-1:0] addr,
   output logic              is_rd,
   output logic              is_wr,
   output logic              is_pen,
   output logic              is_pdis,
   output logic              in_dac,
   output logic [NUM_CH-1:0] ch_sel
);
   localparam int LOW_W = ADDR_W - 1;

   always_comb begin
      is_rd   = valid && (code == OPK_READ);
      is_wr   = valid && (code == OPK_WRITE);
      is_pen  = valid && (code == OPK_PEN);
      is_pdis = valid && (code == OPK_PDIS);
      in_dac  = addr[ADDR_W-1];
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign ch_sel[i] = addr[ADDR_W-1] && (addr[LOW_W-1:0] == LOW_W'(i));
   end
endmodule

// File: rtl/wgp_pen_reg.sv
module wgp_pen_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic pen
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pen <= 1'b0;
      else if (set_req) pen <= 1'b1;
      else if (clr_req) pen <= 1'b0;
   end

   // R2
   pen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> pen);
   // R2
   pen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !set_req) |=> !pen);
   // R2
   pen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_req && !clr_req) |=> $stable(pen));
endmodule

// File: rtl/wgp_pin_sync.sv
module wgp_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level
);
   if (STAGES == 0) begin : g_direct
      assign level = pin;
   end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= {sr[STAGES-2+((STAGES==1)?1:0):0], pin} & {STAGES{1'b1}};
      end
      assign level = sr[STAGES-1];
   end
endmodule

// File: rtl/wgp_strobe.sv
module wgp_strobe #(
   parameter int DAC_W  = 8,
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_rd,
   input  logic              is_wr,
   input  logic              in_dac,
   input  logic [NUM_CH-1:0] ch_sel,
   input  logic              pen,
   input  logic              unlocked,
   input  logic [DAC_W-1:0]  wr_data,
   input  logic [DAC_W-1:0]  rd_data,
   output logic              mem_we,
   output logic [NUM_CH-1:0] latch_ld,
   output logic [DAC_W-1:0]  latch_val
);
   logic              ch_hit;
   logic              we_d;
   logic              ld_go;
   logic [NUM_CH-1:0] ld_d;

   always_comb begin
      ch_hit = |ch_sel;
      we_d   = is_wr && pen && (!in_dac || (ch_hit && unlocked));
      ld_go  = ch_hit && (is_rd || (is_wr && unlocked));
      ld_d   = ch_sel & {NUM_CH{ld_go}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         latch_ld  <= '0;
         latch_val <= '0;
      end else begin
         mem_we   <= we_d;
         latch_ld <= ld_d;
         if (ld_go) latch_val <= is_rd ? rd_data : wr_data;
      end
   end

   // R9
   ld_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(latch_ld));
   // R9
   we_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(is_wr));
   // R9
   ld_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_ld != '0) |-> ($past(is_rd) || $past(is_wr)));
   // R7
   rd_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> !mem_we);
   // R4
   dac_we_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && in_dac) |=> (!mem_we || (latch_ld != '0)));
   // R3
   gen_no_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_dac |=> (latch_ld == '0));
   // R6
   lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && in_dac && !unlocked) |=> (!mem_we && latch_ld == '0));
endmodule

// File: rtl/wr_guard_policy.sv
module wr_guard_policy
   import wgp_pkg::*;
#(
   parameter int ADDR_W    = 9,
   parameter int DAC_W     = 8,
   parameter int NUM_CH    = 4,
   parameter int PROT_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DAC_W-1:0]  wr_data,
   input  logic [DAC_W-1:0]  rd_data,
   input  logic              dac_unlock,
   output logic              mem_we,
   output logic [NUM_CH-1:0] latch_ld,
   output logic [DAC_W-1:0]  latch_val
);
   localparam int REGION = 1 << (ADDR_W - 1);

   if (ADDR_W < 2)                     begin : g_bad_aw  $error("ADDR_W must be at least 2");            end
   if (NUM_CH < 1 || NUM_CH > REGION)  begin : g_bad_ch  $error("NUM_CH must fit the DAC region");       end
   if (DAC_W < 1)                      begin : g_bad_dw  $error("DAC_W must be positive");               end
   if (PROT_SYNC < 0 || PROT_SYNC > 4) begin : g_bad_sy  $error("PROT_SYNC must lie in 0..4");           end

   logic              is_rd, is_wr, is_pen, is_pdis, in_dac;
   logic [NUM_CH-1:0] ch_sel;
   logic              pen;
   logic              unlocked;

   wgp_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
      .valid(op_valid), .code(op_code), .addr(op_addr),
      .is_rd(is_rd), .is_wr(is_wr), .is_pen(is_pen), .is_pdis(is_pdis),
      .in_dac(in_dac), .ch_sel(ch_sel)
   );

   wgp_pen_reg u_pen (
      .clk(clk), .rst_n(rst_n), .set_req(is_pen), .clr_req(is_pdis), .pen(pen)
   );

   wgp_pin_sync #(.STAGES(PROT_SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(dac_unlock), .level(unlocked)
   );

   wgp_strobe #(.DAC_W(DAC_W), .NUM_CH(NUM_CH)) u_stb (
      .clk(clk), .rst_n(rst_n), .is_rd(is_rd), .is_wr(is_wr), .in_dac(in_dac),
      .ch_sel(ch_sel), .pen(pen), .unlocked(unlocked),
      .wr_data(wr_data), .rd_data(rd_data),
      .mem_we(mem_we), .latch_ld(latch_ld), .latch_val(latch_val)
   );

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> (!mem_we && latch_ld == '0));
   // R9
   ctl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OPK_PEN || op_code == OPK_PDIS)) |=> (!mem_we && latch_ld == '0));
endmodule

// File: tb/tb_wr_guard_policy.sv
`timescale 1ns/1ps
module tb_wr_guard_policy;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [2:0] op_code = 3'd0;
   logic [8:0] op_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data = '0;
   logic       dac_unlock = 1'b0;
   logic       mem_we;
   logic [3:0] latch_ld;
   logic [7:0] latch_val;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wr_guard_policy dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_addr(op_addr), .wr_data(wr_data), .rd_data(rd_data),
      .dac_unlock(dac_unlock), .mem_we(mem_we), .latch_ld(latch_ld),
      .latch_val(latch_val)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the following negedge with outputs sampled
   task automatic do_op(input logic [2:0] c, input logic [8:0] a,
                        input logic [7:0] wd, input logic [7:0] rd,
                        input logic v = 1'b1);
      op_valid = v; op_code = c; op_addr = a; wr_data = wd; rd_data = rd;
      @(negedge clk);
      op_valid = 1'b0;
   endtask

   task automatic expect_quiet(input string req);
      check(req, int'(mem_we), 0);
      check(req, int'(latch_ld), 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      bit pen_m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", int'(mem_we), 0);
      check("R1", int'(latch_ld), 0);
      check("R1", int'(latch_val), 0);
      // R1 programming off after reset: general write does not strobe
      dac_unlock = 1'b1;
      repeat (4) @(negedge clk);
      do_op(3'd2, 9'h010, 8'h5A, 8'h00);
      check("R1", int'(mem_we), 0);

      // sweep
      for (int p = 0; p < 2; p++) begin
         dac_unlock = p[0];
         repeat (4) @(negedge clk);
         for (int e = 0; e < 2; e++) begin
            do_op(e ? 3'd3 : 3'd4, 9'h000, 8'h00, 8'h00);
            expect_quiet("R9");
            pen_m = e[0];
            for (int k = 0; k < 2; k++) begin
               for (int j = 0; j < 11; j++) begin
                  logic [8:0] a;
                  logic [7:0] wd, rd;
                  bit dac, chok, exp_we;
                  int exp_ld;
                  string tag;
                  a  = (j < 3) ? 9'(j * 8'h55 + 1) : 9'(9'h100 + j - 3);
                  wd = 8'(a) + 8'h11 + 8'(p * 4 + e * 2);
                  rd = 8'(a) ^ 8'h3C ^ 8'(e);
                  dac  = a[8];
                  chok = dac && (a[7:0] < 4);
                  exp_we = (k == 1) && pen_m && (!dac || (chok && p == 1));
                  exp_ld = (chok && (k == 0 || p == 1)) ? (1 << a[1:0]) : 0;
                  if (!dac)        tag = k ? "R3" : "R7";
                  else if (!chok)  tag = "R8";
                  else if (k == 0) tag = "R7";
                  else if (p == 0) tag = "R6";
                  else             tag = pen_m ? "R4" : "R5";
                  do_op(k ? 3'd2 : 3'd1, a, wd, rd);
                  check(tag, int'(mem_we), int'(exp_we));
                  check(tag, int'(latch_ld), exp_ld);
                  if (exp_ld != 0) check(tag, int'(latch_val), k ? int'(wd) : int'(rd));
               end
            end
         end
      end

      // R9 strobes last one cycle
      do_op(3'd3, 9'h000, 8'h00, 8'h00);
      do_op(3'd2, 9'h101, 8'hA7, 8'h00);
      check("R9", int'(latch_ld), 2);
      @(negedge clk);
      expect_quiet("R9");
      // R9 op_valid low produces nothing
      do_op(3'd2, 9'h020, 8'h01, 8'h02, 1'b0);
      expect_quiet("R9");
      do_op(3'd1, 9'h102, 8'h01, 8'h02, 1'b0);
      expect_quiet("R9");
      // R9 unused opcodes: no strobe, enable unchanged
      for (int c = 5; c < 8; c++) begin
         do_op(3'(c), 9'h103, 8'h01, 8'h02);
         expect_quiet("R9");
      end
      do_op(3'd0, 9'h103, 8'h01, 8'h02);
      expect_quiet("R9");
      do_op(3'd2, 9'h030, 8'h01, 8'h02);
      check("R9", int'(mem_we), 1);

      // R2 persistence through reads and idle cycles
      do_op(3'd1, 9'h040, 8'h00, 8'h00);
      repeat (10) @(negedge clk);
      do_op(3'd2, 9'h041, 8'h33, 8'h00);
      check("R2", int'(mem_we), 1);
      do_op(3'd4, 9'h000, 8'h00, 8'h00);
      repeat (5) @(negedge clk);
      do_op(3'd2, 9'h041, 8'h33, 8'h00);
      check("R2", int'(mem_we), 0);
      do_op(3'd3, 9'h000, 8'h00, 8'h00);

      // R10 synchronizer latency with PROT_SYNC=2
      dac_unlock = 1'b1;
      repeat (4) @(negedge clk);
      dac_unlock = 1'b0;
      do_op(3'd2, 9'h100, 8'h61, 8'h00);
      check("R10", int'(latch_ld), 1);
      do_op(3'd2, 9'h102, 8'h62, 8'h00);
      check("R10", int'(latch_ld), 4);
      check("R10", int'(mem_we), 1);
      do_op(3'd2, 9'h103, 8'h63, 8'h00);
      check("R10", int'(latch_ld), 0);
      check("R10", int'(mem_we), 0);
      // R3 unlock pin low still allows general writes
      do_op(3'd2, 9'h0FF, 8'h64, 8'h00);
      check("R3", int'(mem_we), 1);
      check("R3", int'(latch_ld), 0);
      // R7 read of DAC with pin low still loads
      do_op(3'd1, 9'h103, 8'h00, 8'hC9);
      check("R7", int'(latch_ld), 8);
      check("R7", int'(latch_val), 32'hC9);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule